// File: doc/BRIEF.md
# Bit-Serial Adder-Subtractor with Result Shift Register

This block adds or subtracts two unsigned operands one bit per clock, least significant bit first. A single carry register links consecutive bit positions. A start pulse selects the operation. For addition the carry register is seeded with 0. For subtraction it is seeded with 1 and the second operand's bits are inverted, so the block forms the two's-complement difference. Each result bit enters the top of a right-shift register. After the last bit, the finished word sits in that register with its least significant bit at position 0.

The result register can also be loaded in parallel through an active-low load control. A small control machine counts the bit cycles and raises a one-cycle done flag once the last bit has been stored. The carry left after the top bit is presented on a separate output.

Control states, all named in `sau_pkg`:
- ST_IDLE: waits.
- ST_RUN: processes one bit per cycle.
- ST_DONE: marks completion for one cycle.

Transitions:
- IDLE→RUN when start is high.
- RUN→RUN while bits remain, or when start is high again (restart).
- RUN→DONE after the last bit.
- DONE→IDLE with no start.
- DONE→RUN when start is high.
- Asynchronous reset returns the machine to IDLE.

Top module: `serial_arith_unit`

## Requirements
- R1: With the mode input low at start (mode = 0), the W result bits equal (A + B) mod 2^W.
- R2: With the mode input high at start (mode = 1), the W result bits equal (A + ~B + 1) mod 2^W. For example, 0011 − 0101 gives 1110.
- R3: The clock edge that samples start high loads the carry register with the mode input: 0 for add, 1 for subtract.
- R4: The start cycle stores no result bit. With load_n high, the result register is unchanged across that edge.
- R5: On each bit cycle with load_n high, the new sum bit enters result bit W-1 and every other bit i takes the old bit i+1.
- R6: When the operand bits are presented LSB first on the W cycles after start, the register holds the full result with the LSB in bit 0.
- R7: load_n low loads par_d_i into the result register on that edge. This takes priority over shifting.
- R8: done_o is high for exactly the one cycle that follows the edge storing the W-th bit.
- R9: After the W-th bit, carry_o equals bit W of A + B' + mode, where B' is B for add and ~B for subtract.
- R10: Outside bit cycles, with load_n high, the result register holds its value.
- R11: Reset clears the result register, carry_o and done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Synchronous start pulse; seeds the carry and samples the mode |
| sub_i | input | 1 | Mode: 0 add, 1 subtract (sampled at start) |
| a_bit_i | input | 1 | Serial bit of operand A, LSB first |
| b_bit_i | input | 1 | Serial bit of operand B, LSB first |
| load_n_i | input | 1 | Active-low parallel load of the result register |
| par_d_i | input | W | Parallel load data |
| res_q_o | output | W | Result register contents |
| carry_o | output | 1 | Carry register (final carry-out after the last bit) |
| done_o | output | 1 | One-cycle completion flag |

## Verification
The bench builds the block with the default width W = 4. At this width every operand pair is small enough to enumerate, and the wrap-around of the two's-complement difference is reached in only a few cycles. Besides the directed sums and differences, the random operand pairs cover carry and borrow chains through all four bit positions. Further cases cover a parallel load before start, a restart issued during the DONE cycle, and idle periods of several cycles that check the register holds its value.

// File: rtl/sau_pkg.sv
package sau_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } sau_state_e;
endpackage

// File: rtl/sau_bitcell.sv
module sau_bitcell (
    input  logic a_i,
    input  logic b_i,
    input  logic inv_i,
    input  logic cin_i,
    output logic sum_o,
    output logic cout_o
);
    logic b_eff;

    always_comb begin
        b_eff  = b_i ^ inv_i;
        sum_o  = a_i ^ b_eff ^ cin_i;
        cout_o = (a_i & b_eff) | (a_i & cin_i) | (b_eff & cin_i);
    end
endmodule

// File: rtl/sau_ctrl.sv
module sau_ctrl #(
    parameter int W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic sub_i,
    output logic step_o,
    output logic mode_o,
    output logic done_o
);
    import sau_pkg::*;

    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    sau_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          mode_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = start_i ? ST_RUN : ST_IDLE;
            ST_RUN:  state_d = start_i ? ST_RUN :
                               ((cnt_q == LAST) ? ST_DONE : ST_RUN);
            ST_DONE: state_d = start_i ? ST_RUN : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (start_i) begin
                cnt_q  <= '0;
                mode_q <= sub_i;
            end else if (state_q == ST_RUN) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        step_o = (state_q == ST_RUN) && !start_i;
        mode_o = mode_q;
        done_o = (state_q == ST_DONE);
    end

    // R8: the completion flag never lasts two cycles
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: the last bit cycle is always followed by the flag
    assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && cnt_q == LAST) |=> done_o);
endmodule

// File: rtl/sau_shreg.sv
module sau_shreg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         shift_i,
    input  logic         sin_i,
    input  logic [W-1:0] par_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic nxt;
        if (i == W - 1) begin : g_top
            assign nxt = sin_i;
        end else begin : g_low
            assign nxt = q_q[i+1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       q_q[i] <= 1'b0;
            else if (load_i)  q_q[i] <= par_i[i];
            else if (shift_i) q_q[i] <= nxt;
        end
    end

    assign q_o = q_q;

    // R7: a parallel load takes the data word
    assert_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (q_o == $past(par_i)));

    // R5: the serial bit enters the top, the rest moves down one place
    assert_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !load_i) |=>
            (q_o[W-1] == $past(sin_i)) && (q_o[W-2:0] == $past(q_o[W-1:1])));

    // R10: no load and no shift leaves the word unchanged
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_i && !load_i) |=> $stable(q_o));
endmodule

// File: rtl/serial_arith_unit.sv
module serial_arith_unit #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         sub_i,
    input  logic         a_bit_i,
    input  logic         b_bit_i,
    input  logic         load_n_i,
    input  logic [W-1:0] par_d_i,
    output logic [W-1:0] res_q_o,
    output logic         carry_o,
    output logic         done_o
);
    logic step, mode, sum_bit, cout, carry_q;

    sau_ctrl #(.W(W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(start_i),
        .sub_i  (sub_i),
        .step_o (step),
        .mode_o (mode),
        .done_o (done_o)
    );

    sau_bitcell u_cell (
        .a_i   (a_bit_i),
        .b_i   (b_bit_i),
        .inv_i (mode),
        .cin_i (carry_q),
        .sum_o (sum_bit),
        .cout_o(cout)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        carry_q <= 1'b0;
        else if (start_i)  carry_q <= sub_i;
        else if (step)     carry_q <= cout;
    end

    sau_shreg #(.W(W)) u_sreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (!load_n_i),
        .shift_i(step),
        .sin_i  (sum_bit),
        .par_i  (par_d_i),
        .q_o    (res_q_o)
    );

    assign carry_o = carry_q;

    // R3: start seeds the carry with the mode input
    assert_carry_seed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (carry_o == $past(sub_i)));

    // R4: the start cycle stores no result bit
    assert_start_noshift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && load_n_i) |=> $stable(res_q_o));
endmodule

// File: tb/sim_serial_arith_unit.sv
`timescale 1ns/1ps
module sim_serial_arith_unit;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         sub_i = 1'b0;
    logic         a_bit_i = 1'b0;
    logic         b_bit_i = 1'b0;
    logic         load_n_i = 1'b1;
    logic [W-1:0] par_d_i = '0;
    logic [W-1:0] res_q_o;
    logic         carry_o;
    logic         done_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    serial_arith_unit #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .sub_i(sub_i),
        .a_bit_i(a_bit_i), .b_bit_i(b_bit_i), .load_n_i(load_n_i),
        .par_d_i(par_d_i), .res_q_o(res_q_o), .carry_o(carry_o), .done_o(done_o)
    );

    function automatic logic [W:0] ref_op(input logic [W-1:0] a, input logic [W-1:0] b,
                                          input logic sub);
        logic [W-1:0] bb;
        bb = sub ? ~b : b;
        return {1'b0, a} + {1'b0, bb} + {{W{1'b0}}, sub};
    endfunction

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic sub,
                          input logic restart_check);
        logic [W:0] e;
        logic [W-1:0] prev;
        logic [W-1:0] bb;
        logic c;
        e  = ref_op(a, b, sub);
        bb = sub ? ~b : b;
        c  = sub;
        start_i = 1'b1; sub_i = sub; load_n_i = 1'b1;
        prev = res_q_o;
        @(negedge clk);
        start_i = 1'b0; sub_i = 1'b0;
        chk(carry_o == sub, "R3 carry seed", carry_o, sub);
        chk(res_q_o == prev, "R4 no shift on start", res_q_o, prev);
        for (int i = 0; i < W; i++) begin
            logic s;
            a_bit_i = a[i]; b_bit_i = b[i];
            s = a[i] ^ bb[i] ^ c;
            c = (a[i] & bb[i]) | (a[i] & c) | (bb[i] & c);
            prev = res_q_o;
            @(negedge clk);
            chk(res_q_o == {s, prev[W-1:1]}, "R5 shift order", res_q_o, {s, prev[W-1:1]});
            if (i < W - 1) chk(done_o == 1'b0, "R8 no early done", done_o, 0);
        end
        a_bit_i = 1'b0; b_bit_i = 1'b0;
        chk(res_q_o == e[W-1:0], sub ? "R2 R6 difference" : "R1 R6 sum", res_q_o, e[W-1:0]);
        chk(carry_o == e[W], "R9 carry out", carry_o, e[W]);
        chk(done_o == 1'b1, "R8 done high", done_o, 1);
        if (!restart_check) begin
            @(negedge clk);
            chk(done_o == 1'b0, "R8 done one cycle", done_o, 0);
            chk(res_q_o == e[W-1:0], "R10 hold after done", res_q_o, e[W-1:0]);
        end
    endtask

    initial begin : watchdog
        #400000;
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk(res_q_o == '0, "R11 reset result", res_q_o, 0);
        chk(carry_o == 1'b0, "R11 reset carry", carry_o, 0);
        chk(done_o == 1'b0, "R11 reset done", done_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        load_n_i = 1'b0; par_d_i = 4'b1011;
        @(negedge clk);
        load_n_i = 1'b1;
        chk(res_q_o == 4'b1011, "R7 parallel load", res_q_o, 4'b1011);
        repeat (3) @(negedge clk);
        chk(res_q_o == 4'b1011, "R10 idle hold", res_q_o, 4'b1011);

        run_op(4'b0001, 4'b0011, 1'b0, 1'b0);
        run_op(4'b0101, 4'b0010, 1'b0, 1'b0);
        run_op(4'b0101, 4'b0011, 1'b1, 1'b0);
        run_op(4'b0011, 4'b0101, 1'b1, 1'b1);
        run_op(4'b1111, 4'b0001, 1'b0, 1'b0);
        run_op(4'b0000, 4'b0000, 1'b1, 1'b0);

        load_n_i = 1'b0; par_d_i = 4'b0110;
        @(negedge clk);
        load_n_i = 1'b1;
        chk(res_q_o == 4'b0110, "R7 load while idle", res_q_o, 4'b0110);

        for (int n = 0; n < 40; n++) begin
            logic [W-1:0] ra, rb;
            ra = W'($urandom);
            rb = W'($urandom);
            run_op(ra, rb, 1'($urandom), 1'($urandom));
        end
        @(negedge clk);

        start_i = 1'b1; sub_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        a_bit_i = 1'b1; b_bit_i = 1'b1;
        load_n_i = 1'b0; par_d_i = 4'b1001;
        @(negedge clk);
        load_n_i = 1'b1;
        chk(res_q_o == 4'b1001, "R7 load beats shift", res_q_o, 4'b1001);
        a_bit_i = 1'b0; b_bit_i = 1'b0;
        repeat (5) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule